// File: doc/BRIEF.md
# Stereo Volume and Soft-Mute Gain Stage

This block scales a two-channel stream of 24-bit signed PCM samples by a gain built from two parts: a fixed attenuation picked by a 6-bit volume code, and a mute envelope. The envelope follows a raised-cosine curve, so muting and unmuting fade the signal in and out instead of cutting it. Each input sample moves the envelope one position toward zero while the mute request is high, or toward full scale while it is low. A request that flips in the middle of a fade turns the fade around from the position it has reached.

After reset the envelope sits at zero, so the stage stays silent until the mute request is released. A status output reports a completed mute. Each result is registered and appears one clock after its input strobe. Both channels use the same combined gain in the same cycle.

Top module: `softmute_volume`

## Requirements
- R1: While reset is held, and after its release, mute_done is 1, out_valid is 0 and both output samples are 0.
- R2: out_valid is in_valid delayed by one clock. The output samples change only in the clock after an in_valid cycle and keep their value otherwise.
- R3: The volume gain in unsigned Q16 is G(c) = F[c mod 6] >> (c div 6), where F = {65536, 58409, 52057, 46396, 41350, 36854}. Codes 60 to 63 give G = 0.
- R4: The envelope has positions p = 0..32 with E(p) = round(32768 * (1 - cos(pi*p/32))). So E(0) = 0 and E(32) = 65536.
- R5: The combined gain is g = floor((G*E + 32768) / 65536). Each output is floor((x*g + 32768) / 65536), saturated to the signed 24-bit range. x is the input sample and E is taken at the position held before the sample's own step.
- R6: Each in_valid cycle moves the position one step: down with mute_req high, up with mute_req low, clamped to 0..32. Without in_valid the position does not change. A full fade therefore takes 32 samples.
- R7: A change of mute_req during a fade reverses the direction from the current position, with no jump.
- R8: mute_done is 1 exactly when the position is 0. It goes low in the clock after the first unmuting sample.
- R9: While the position is 0, every output sample is 0 whatever the input or the volume code.
- R10: Left and right are scaled by the same gain in the same sample, and each output depends only on its own channel's input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Strobe marking a new stereo sample |
| in_left | input | 24 | Left input sample, two's complement |
| in_right | input | 24 | Right input sample, two's complement |
| vol_code | input | 6 | Attenuation code, about 1 dB per step |
| mute_req | input | 1 | 1 fades toward silence, 0 fades toward full level |
| out_valid | output | 1 | Output sample strobe |
| out_left | output | 24 | Scaled left sample |
| out_right | output | 24 | Scaled right sample |
| mute_done | output | 1 | Envelope is at zero |

## Verification
The bench drives a full fade-in of full-scale positive and negative samples. A wrong curve value or an off-by-one in which envelope position is applied shows up as a single wrong sample in that fade. It sweeps all 64 volume codes at full envelope, where an error in the octave shift or in the codes that give full attenuation produces a wrong level. Idle gaps inside a fade catch a design that steps without a strobe, and a mute that is reversed halfway catches a design that restarts the curve instead of turning it around. A long random run, with unequal channels and toggling mute, catches rounding that is biased on negative samples and channels that are swapped.

// File: rtl/svol_pkg.sv
package svol_pkg;
  localparam int SAMPLE_W   = 24;
  localparam int GAIN_FRAC  = 16;
  localparam int GAIN_W     = GAIN_FRAC + 1;
  localparam int VOL_W      = 6;
  localparam int RAMP_STEPS = 32;
  localparam int POS_W      = $clog2(RAMP_STEPS + 1);
  localparam int MUTE_CODE  = 60;
  localparam int CH_N       = 2;

  typedef logic [GAIN_W-1:0]          gain_t;
  typedef logic signed [SAMPLE_W-1:0] sample_t;
endpackage

// File: rtl/svol_rst_sync.sv
module svol_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign srst_n = sync_q;
endmodule

// File: rtl/svol_vol_rom.sv
module svol_vol_rom
  import svol_pkg::*;
#(
  parameter int CODE_W    = VOL_W,
  parameter int MUTE_FROM = MUTE_CODE
) (
  input  logic [CODE_W-1:0] code_i,
  output gain_t             gain_o
);
  // fractional part of the gain for 0..5 dB, unsigned Q16
  localparam gain_t FRAC_DB [6] = '{17'd65536, 17'd58409, 17'd52057,
                                    17'd46396, 17'd41350, 17'd36854};

  logic [2:0] frac_sel;
  logic [3:0] octave;

  always_comb begin
    frac_sel = 3'(code_i % 6);
    octave   = 4'(code_i / 6);
    if (int'(code_i) >= MUTE_FROM) gain_o = '0;
    else                           gain_o = FRAC_DB[frac_sel] >> octave;
  end
endmodule

// File: rtl/svol_env_ramp.sv
module svol_env_ramp
  import svol_pkg::*;
#(
  parameter int STEPS = RAMP_STEPS,
  parameter int PW    = POS_W
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  step_i,
  input  logic  mute_i,
  output gain_t env_o,
  output logic  done_o
);
  localparam int    HALF     = STEPS / 2;
  localparam gain_t ENV_FULL = gain_t'(1 << GAIN_FRAC);
  // rising half of the raised-cosine curve, positions 0..16
  localparam gain_t RISE [17] = '{
    17'd0,     17'd158,   17'd630,   17'd1411,  17'd2494,  17'd3869,
    17'd5522,  17'd7438,  17'd9598,  17'd11980, 17'd14563, 17'd17321,
    17'd20228, 17'd23256, 17'd26375, 17'd29556, 17'd32768};

  logic [PW-1:0] pos_q, pos_d;

  always_comb begin
    pos_d = pos_q;
    if (step_i) begin
      if (mute_i) begin
        if (pos_q != '0) pos_d = pos_q - 1'b1;
      end else if (pos_q != PW'(STEPS)) begin
        pos_d = pos_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= pos_d;
  end

  // second half mirrors the first about the midpoint
  always_comb begin
    if (int'(pos_q) <= HALF) env_o = RISE[5'(pos_q)];
    else                     env_o = ENV_FULL - RISE[5'(PW'(STEPS) - pos_q)];
  end

  assign done_o = (pos_q == '0);

  AST_POS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pos_q) <= STEPS) else $error("position out of range"); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |=> $stable(pos_q)) else $error("position moved without a sample"); // R6
  AST_ENV_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !mute_i && !done_o && int'(pos_q) < STEPS) |=> env_o > $past(env_o))
    else $error("envelope did not rise"); // R4
  AST_REVERSE_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && mute_i && !done_o) |=> env_o < $past(env_o))
    else $error("envelope did not fall"); // R7
endmodule

// File: rtl/svol_gain_mult.sv
module svol_gain_mult
  import svol_pkg::*;
#(
  parameter int DW = SAMPLE_W,
  parameter int GW = GAIN_W,
  parameter int FB = GAIN_FRAC
) (
  input  logic signed [DW-1:0] sample_i,
  input  logic [GW-1:0]        gain_i,
  output logic signed [DW-1:0] sample_o
);
  localparam int PROD_W = DW + GW + 1;
  localparam int SH_W   = PROD_W - FB;
  localparam logic signed [PROD_W-1:0] RND  = PROD_W'(1) <<< (FB - 1);
  localparam logic signed [SH_W-1:0]   MAXV = SH_W'((64'sd1 <<< (DW - 1)) - 1);
  localparam logic signed [SH_W-1:0]   MINV = SH_W'(-(64'sd1 <<< (DW - 1)));

  logic signed [PROD_W-1:0] prod;
  logic signed [SH_W-1:0]   shifted;

  always_comb begin
    prod    = PROD_W'(sample_i) * PROD_W'($signed({1'b0, gain_i}));
    shifted = SH_W'((prod + RND) >>> FB);
    if (shifted > MAXV)      sample_o = DW'(MAXV);
    else if (shifted < MINV) sample_o = DW'(MINV);
    else                     sample_o = DW'(shifted);
  end
endmodule

// File: rtl/softmute_volume.sv
module softmute_volume
  import svol_pkg::*;
#(
  parameter int DW    = SAMPLE_W,
  parameter int CW    = VOL_W,
  parameter int STEPS = RAMP_STEPS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_left,
  input  logic signed [DW-1:0] in_right,
  input  logic [CW-1:0]        vol_code,
  input  logic                 mute_req,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_left,
  output logic signed [DW-1:0] out_right,
  output logic                 mute_done
);
  localparam int GG_W = 2 * GAIN_W;

  logic  srst_n;
  gain_t vol_gain, env, g_eff;
  logic [GG_W-1:0] gg;
  logic signed [DW-1:0] in_ch  [CH_N];
  logic signed [DW-1:0] scaled [CH_N];
  logic signed [DW-1:0] out_q  [CH_N];
  logic signed [DW-1:0] out_d  [CH_N];
  logic vld_q;

  svol_rst_sync u_rst (.clk(clk), .arst_n(rst_n), .srst_n(srst_n));

  svol_vol_rom #(.CODE_W(CW)) u_rom (.code_i(vol_code), .gain_o(vol_gain));

  svol_env_ramp #(.STEPS(STEPS)) u_env (
    .clk(clk), .rst_n(srst_n), .step_i(in_valid), .mute_i(mute_req),
    .env_o(env), .done_o(mute_done));

  always_comb begin
    gg    = GG_W'(vol_gain) * GG_W'(env) + GG_W'(1 << (GAIN_FRAC - 1));
    g_eff = gain_t'(gg >> GAIN_FRAC);
  end

  assign in_ch[0] = in_left;
  assign in_ch[1] = in_right;

  for (genvar ch = 0; ch < CH_N; ch++) begin : g_ch
    svol_gain_mult #(.DW(DW)) u_mul (
      .sample_i(in_ch[ch]), .gain_i(g_eff), .sample_o(scaled[ch]));

    always_comb begin
      out_d[ch] = out_q[ch];
      if (in_valid) out_d[ch] = scaled[ch];
    end

    always_ff @(posedge clk or negedge srst_n) begin
      if (!srst_n) out_q[ch] <= '0;
      else         out_q[ch] <= out_d[ch];
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) vld_q <= 1'b0;
    else         vld_q <= in_valid;
  end

  assign out_valid = vld_q;
  assign out_left  = out_q[0];
  assign out_right = out_q[1];

  function automatic logic [DW:0] mag(input logic signed [DW-1:0] v);
    return (v < 0) ? (DW+1)'(-(DW+1)'(v)) : (DW+1)'(v);
  endfunction

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!srst_n)
    in_valid |=> out_valid) else $error("missing output strobe"); // R2
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!srst_n)
    !in_valid |=> (!out_valid && $stable(out_left) && $stable(out_right)))
    else $error("output changed without input"); // R2
  AST_SILENT_MUTE: assert property (@(posedge clk) disable iff (!srst_n)
    (in_valid && mute_done) |=> (out_left == '0 && out_right == '0))
    else $error("sound while muted"); // R9
  AST_NO_GROWTH: assert property (@(posedge clk) disable iff (!srst_n)
    in_valid |=> (mag(out_left) <= mag($past(in_left)) && mag(out_right) <= mag($past(in_right))))
    else $error("output larger than input"); // R5
endmodule

// File: tb/softmute_volume_test.sv
`timescale 1ns/1ps
module softmute_volume_test;
  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, mute_req;
  logic signed [23:0] in_left, in_right;
  logic [5:0] vol_code;
  logic out_valid, mute_done;
  logic signed [23:0] out_left, out_right;

  int n_checks = 0;
  int n_fails  = 0;
  int m_pos    = 0;
  logic signed [23:0] exp_l = '0, exp_r = '0;

  always #4 clk = ~clk;

  softmute_volume uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_left(in_left),
    .in_right(in_right), .vol_code(vol_code), .mute_req(mute_req),
    .out_valid(out_valid), .out_left(out_left), .out_right(out_right),
    .mute_done(mute_done));

  function automatic longint vol_gain(int c);
    int f [6] = '{65536, 58409, 52057, 46396, 41350, 36854};
    if (c >= 60) return 0;
    return longint'(f[c % 6] >> (c / 6));
  endfunction

  function automatic longint env_gain(int p);
    real pi = 3.14159265358979323846;
    return longint'($floor(32768.0 * (1.0 - $cos(pi * p / 32.0)) + 0.5));
  endfunction

  function automatic logic signed [23:0] scale(logic signed [23:0] x, int c, int p);
    longint g, r;
    g = (vol_gain(c) * env_gain(p) + 32768) >>> 16;
    r = (longint'(x) * g + 32768) >>> 16;
    if (r > 8388607)  r = 8388607;
    if (r < -8388608) r = -8388608;
    return 24'(r);
  endfunction

  task automatic check(string tag, string what, longint act, longint exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic step(string tag, bit v, int l, int r, int c, bit m);
    in_valid = v; in_left = 24'(l); in_right = 24'(r); vol_code = 6'(c); mute_req = m;
    @(posedge clk);
    @(negedge clk);
    if (v) begin
      exp_l = scale(24'(l), c, m_pos);
      exp_r = scale(24'(r), c, m_pos);
      if (m && m_pos > 0) m_pos--;
      else if (!m && m_pos < 32) m_pos++;
    end
    check(tag, "left", out_left, exp_l);
    check(tag, "right", out_right, exp_r);
    check("R2", "out_valid", out_valid, v);
    check("R8", "mute_done", mute_done, m_pos == 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20251));
    rst_n = 1'b0; in_valid = 1'b0; in_left = '0; in_right = '0;
    vol_code = '0; mute_req = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", "mute_done in reset", mute_done, 1);
    check("R1", "out_valid in reset", out_valid, 0);
    check("R1", "left in reset", out_left, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", "mute_done after reset", mute_done, 1);
    check("R1", "right after reset", out_right, 0);

    // R9: held mute, loud input, position stays at zero
    for (int i = 0; i < 4; i++) step("R9", 1, 8388607, -8388608, 0, 1);

    // R4: full fade-in with full-scale samples, idle gaps inside (R6)
    for (int i = 0; i < 34; i++) begin
      step("R4", 1, 8388607, -8388608, 0, 0);
      if (i % 7 == 3) step("R6", 0, 1234, 5678, 0, 0);
    end

    // R3: every volume code at full envelope
    for (int c = 0; c < 64; c++)
      step("R3", 1, 8388607 - c * 1000, -7000000 + c * 77, c, 0);

    // R7: fade down part way, then reverse, then mute fully
    for (int i = 0; i < 10; i++) step("R7", 1, 4000000, -4000001, 3, 1);
    for (int i = 0; i < 5; i++)  step("R7", 1, 4000000, -4000001, 3, 0);
    for (int i = 0; i < 30; i++) step("R8", 1, -3, 3, 3, 1);
    step("R9", 1, 8388607, 8388607, 0, 1);
    step("R8", 1, 100000, 100000, 0, 0);

    // R5 / R10: random traffic
    begin
      bit m = 1'b0;
      for (int i = 0; i < 4000; i++) begin
        if ($urandom % 40 == 0) m = ~m;
        step(i % 2 ? "R5" : "R10", ($urandom % 10) < 7, int'($urandom), int'($urandom),
             int'($urandom % 64), m);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule